// File: doc/BRIEF.md
# Replaying-source linked-list DMA channel

This block is one DMA channel that moves data in a series of buffers. Software writes a start source address and a pointer to the first descriptor, then sets the channel's enable bit. For each buffer the channel reads a four-word descriptor from memory that gives the destination address, a length word, a mode word and the pointer to the next descriptor. It copies the buffer one word at a time. It then marks the descriptor's length word as done in memory and restores the source address to the start value. Every buffer therefore reads the same source region and writes it to a new destination.

A zero next-descriptor pointer ends the chain. The channel then drops its own enable, which makes it free again, and raises the transfer-complete interrupt. Each buffer before the last raises a buffer-complete interrupt. When a descriptor's automatic bit is clear, the channel stops after that buffer and waits for a software resume before it fetches the next descriptor. Interrupt status is sticky, and a read of the status register clears it. All memory traffic goes through one word-wide request/grant master port.

Top module: `dma_replay_chain`

## Requirements
- R1: Register offset 0 (control) reads the channel enable in bit 0. It reads 0 after reset and again once a chain has finished, and 1 while the channel is running.
- R2: Register offset 3 (status) returns buffer-complete in bit 0 and transfer-complete in bit 1. The read clears both bits, so a second read returns 0. Outputs irq_buf and irq_xfer follow these bits.
- R3: Before each buffer the channel reads four words at pointer+0 to pointer+3. Their meanings are destination address, length word, mode word and next pointer, in that order.
- R4: A buffer copies its length in words (length word bits LEN_W-1:0) from source to destination in rising address order. Every buffer starts again at the source address held in offset 1.
- R5: After a buffer's data, the channel writes the length word back to pointer+1 with bit DW-1 set and all other bits unchanged.
- R6: Every buffer whose next pointer is non-zero sets the buffer-complete status. The last buffer does not set it.
- R7: When a buffer with a zero next pointer has been written back, the channel clears its enable and sets the transfer-complete status.
- R8: The channel makes no memory request until software writes 1 to bit 0 of offset 0.
- R9: If the mode word has bit 0 (automatic) set, the next descriptor is fetched at once. If bit 0 is clear, the channel makes no request until software writes bit 1 of offset 0 (resume).
- R10: A memory request that is not granted keeps its address, direction and write data unchanged in the next cycle.
- R11: A length of 0 moves no data, but the writeback still happens and the chain goes on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a status read clears status) |
| reg_addr | input | 2 | Register word offset |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data, valid while reg_rd is high |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | AW | Word address |
| mem_wdata | output | DW | Write data |
| mem_gnt | input | 1 | Grant; the access completes in this cycle |
| mem_rdata | input | DW | Read data, valid in the grant cycle |
| irq_buf | output | 1 | Buffer-complete interrupt (sticky) |
| irq_xfer | output | 1 | Transfer-complete interrupt (sticky) |

## Verification
The bench builds the channel with AW = 8 and LEN_W = 6. With AW = 8 the whole address space is a 256-word array, so descriptors, the replayed source region and every destination fit in the bench and can be inspected. The memory withholds the grant one cycle in four, which exercises held requests in the fetch, copy and writeback phases. The chains include a zero-length buffer, a single-buffer chain and a chain that pauses on a clear automatic bit.

// File: rtl/dma_seq_pkg.sv
package dma_seq_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_XFER, S_WB, S_RELOAD, S_WAIT, S_DONE
  } seq_state_t;

  localparam int REG_AW    = 2;
  localparam int LLI_WORDS = 4;
  localparam int LLI_DST   = 0;
  localparam int LLI_LEN   = 1;
  localparam int LLI_MODE  = 2;
  localparam int LLI_NEXT  = 3;

  localparam logic [REG_AW-1:0] OFF_CTRL = 2'd0;
  localparam logic [REG_AW-1:0] OFF_SRC  = 2'd1;
  localparam logic [REG_AW-1:0] OFF_DESC = 2'd2;
  localparam logic [REG_AW-1:0] OFF_STAT = 2'd3;
endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_seq_pkg::*;
#(
  parameter int AW = 16,
  parameter int DW = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  input  logic              hw_clr,
  input  logic              buf_evt,
  input  logic              xfer_evt,
  output logic              chan_en,
  output logic              resume,
  output logic [AW-1:0]     src_base,
  output logic [AW-1:0]     desc_base,
  output logic              irq_buf,
  output logic              irq_xfer
);
  logic en_q, stat_buf_q, stat_xfer_q;
  logic wr_ctrl, rd_stat;
  logic unused_wdata;

  assign wr_ctrl      = reg_wr && (reg_addr == OFF_CTRL);
  assign rd_stat      = reg_rd && (reg_addr == OFF_STAT);
  assign resume       = wr_ctrl && reg_wdata[1];
  assign unused_wdata = ^reg_wdata;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q        <= 1'b0;
      stat_buf_q  <= 1'b0;
      stat_xfer_q <= 1'b0;
      src_base    <= '0;
      desc_base   <= '0;
    end else begin
      if (hw_clr)                       en_q <= 1'b0;
      else if (wr_ctrl && reg_wdata[0]) en_q <= 1'b1;
      if (reg_wr && reg_addr == OFF_SRC)  src_base  <= reg_wdata[AW-1:0];
      if (reg_wr && reg_addr == OFF_DESC) desc_base <= reg_wdata[AW-1:0];
      if (buf_evt)      stat_buf_q <= 1'b1;
      else if (rd_stat) stat_buf_q <= 1'b0;
      if (xfer_evt)     stat_xfer_q <= 1'b1;
      else if (rd_stat) stat_xfer_q <= 1'b0;
    end
  end

  always_comb begin
    unique case (reg_addr)
      OFF_CTRL: reg_rdata = DW'(en_q);
      OFF_SRC:  reg_rdata = DW'(src_base);
      OFF_DESC: reg_rdata = DW'(desc_base);
      default:  reg_rdata = DW'({stat_xfer_q, stat_buf_q});
    endcase
  end

  assign chan_en  = en_q;
  assign irq_buf  = stat_buf_q;
  assign irq_xfer = stat_xfer_q;

  // R7: completion drops the enable
  p_en_cleared_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hw_clr |=> !chan_en);
  // R6: a buffer event leaves the buffer status pending
  p_status_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    buf_evt |=> irq_buf);
endmodule

// File: rtl/dma_chan_seq.sv
module dma_chan_seq
  import dma_seq_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int LEN_W = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          chan_en,
  input  logic          resume,
  input  logic [AW-1:0] src_base,
  input  logic [AW-1:0] desc_base,
  output logic          hw_clr,
  output logic          buf_evt,
  output logic          xfer_evt,
  output logic          mem_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic          mem_gnt,
  input  logic [DW-1:0] mem_rdata
);
  localparam int IDX_W = $clog2(LLI_WORDS);

  function automatic logic [DW-1:0] done_word(input logic [DW-1:0] w);
    return w | (DW'(1) << (DW - 1));
  endfunction

  function automatic logic [LEN_W-1:0] buf_len(input logic [DW-1:0] w);
    return w[LEN_W-1:0];
  endfunction

  seq_state_t       state;
  logic [IDX_W-1:0] idx;
  logic [LEN_W-1:0] cnt;
  logic             phase;
  logic [DW-1:0]    hold, len_word, mode_word;
  logic [AW-1:0]    cur_desc, src_cur, dst_cur, nxt;
  logic             reload_evt, buf_left, unused_mode;

  assign reload_evt  = (state == S_RELOAD);
  assign buf_evt     = reload_evt && (nxt != '0);
  assign xfer_evt    = (state == S_DONE);
  assign hw_clr      = xfer_evt;
  assign buf_left    = (cnt != buf_len(len_word));
  assign unused_mode = ^mode_word;

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    unique case (state)
      S_FETCH: begin
        mem_req  = 1'b1;
        mem_addr = cur_desc + AW'(idx);
      end
      S_XFER: if (buf_left) begin
        mem_req = 1'b1;
        if (!phase) mem_addr = src_cur;
        else begin
          mem_we    = 1'b1;
          mem_addr  = dst_cur;
          mem_wdata = hold;
        end
      end
      S_WB: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = cur_desc + AW'(LLI_LEN);
        mem_wdata = done_word(len_word);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      idx       <= '0;
      cnt       <= '0;
      phase     <= 1'b0;
      hold      <= '0;
      len_word  <= '0;
      mode_word <= '0;
      cur_desc  <= '0;
      src_cur   <= '0;
      dst_cur   <= '0;
      nxt       <= '0;
    end else begin
      unique case (state)
        S_IDLE: if (chan_en) begin
          cur_desc <= desc_base;
          src_cur  <= src_base;
          idx      <= '0;
          state    <= S_FETCH;
        end
        S_FETCH: if (mem_gnt) begin
          unique case (int'(idx))
            LLI_DST:  dst_cur   <= mem_rdata[AW-1:0];
            LLI_LEN:  len_word  <= mem_rdata;
            LLI_MODE: mode_word <= mem_rdata;
            default:  nxt       <= mem_rdata[AW-1:0];
          endcase
          idx <= idx + 1'b1;
          if (int'(idx) == LLI_WORDS - 1) begin
            cnt   <= '0;
            phase <= 1'b0;
            state <= S_XFER;
          end
        end
        S_XFER: begin
          if (!buf_left) state <= S_WB;
          else if (mem_gnt) begin
            if (!phase) begin
              hold  <= mem_rdata;
              phase <= 1'b1;
            end else begin
              phase   <= 1'b0;
              src_cur <= src_cur + 1'b1;
              dst_cur <= dst_cur + 1'b1;
              cnt     <= cnt + 1'b1;
            end
          end
        end
        S_WB: if (mem_gnt) state <= S_RELOAD;
        S_RELOAD: begin
          src_cur <= src_base;
          if (nxt == '0) state <= S_DONE;
          else begin
            cur_desc <= nxt;
            idx      <= '0;
            state    <= mode_word[0] ? S_FETCH : S_WAIT;
          end
        end
        S_WAIT: if (resume) state <= S_FETCH;
        default: state <= S_IDLE;
      endcase
    end
  end

  // R10: an ungranted request is held
  p_req_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                               && $stable(mem_wdata)));
  // R4: source restarts from the programmed start after each buffer
  p_src_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reload_evt |=> (src_cur == $past(src_base)));
  // R8: no start without the enable
  p_idle_until_enable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE && !chan_en) |=> (state == S_IDLE && !mem_req));
  // R9: a paused channel stays silent until resumed
  p_wait_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_WAIT && !resume) |=> !mem_req);
endmodule

// File: rtl/dma_replay_chain.sv
module dma_replay_chain
  import dma_seq_pkg::*;
#(
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int LEN_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DW-1:0]     reg_wdata,
  output logic [DW-1:0]     reg_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [AW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_wdata,
  input  logic              mem_gnt,
  input  logic [DW-1:0]     mem_rdata,
  output logic              irq_buf,
  output logic              irq_xfer
);
  logic          chan_en, resume, hw_clr, buf_evt, xfer_evt;
  logic [AW-1:0] src_base, desc_base;

  dma_chan_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .hw_clr(hw_clr), .buf_evt(buf_evt), .xfer_evt(xfer_evt),
    .chan_en(chan_en), .resume(resume), .src_base(src_base),
    .desc_base(desc_base), .irq_buf(irq_buf), .irq_xfer(irq_xfer)
  );

  dma_chan_seq #(.AW(AW), .DW(DW), .LEN_W(LEN_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .chan_en(chan_en), .resume(resume),
    .src_base(src_base), .desc_base(desc_base), .hw_clr(hw_clr),
    .buf_evt(buf_evt), .xfer_evt(xfer_evt), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_gnt(mem_gnt), .mem_rdata(mem_rdata)
  );
endmodule

// File: tb/dma_replay_chain_test.sv
module dma_replay_chain_test;
  localparam int AW = 8;
  localparam int DW = 32;
  localparam int LW = 6;
  localparam logic [AW-1:0] SRC = 8'h10;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n, reg_wr, reg_rd, mem_req, mem_we, mem_gnt, irq_buf, irq_xfer;
  logic [1:0]    reg_addr;
  logic [DW-1:0] reg_wdata, reg_rdata, mem_wdata, mem_rdata;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem [0:255];
  logic [1:0]    sc;
  int tests = 0, fails = 0;

  typedef struct packed { logic [AW-1:0] a; logic [DW-1:0] d; } wr_t;
  wr_t exp_q[$];

  dma_replay_chain #(.AW(AW), .DW(DW), .LEN_W(LW)) uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
    .irq_buf(irq_buf), .irq_xfer(irq_xfer)
  );

  // memory model: the grant is withheld one cycle in four
  always @(posedge clk) sc <= (rst_n === 1'b1) ? sc + 2'd1 : 2'd0;
  assign mem_gnt   = mem_req && (sc != 2'd2);
  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) if (mem_req && mem_gnt && mem_we) mem[mem_addr] <= mem_wdata;

  task automatic chk(input string rq, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", rq, act, exp);
    end
  endtask

  // scoreboard monitor: every granted write must match the next expected one
  always @(negedge clk) if (rst_n && mem_req && mem_gnt && mem_we) begin
    wr_t e;
    if (exp_q.size() == 0) chk("R4/R5 unexpected write", {24'd0, mem_addr}, 32'hFFFF_FFFF);
    else begin
      e = exp_q.pop_front();
      chk("R4/R5 write address", {24'd0, mem_addr}, {24'd0, e.a});
      chk("R4/R5 write data", mem_wdata, e.d);
    end
  end

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [DW-1:0] d);
    @(negedge clk); reg_rd = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  // driver: writes a descriptor and queues the writes it should cause
  task automatic put_lli(input logic [AW-1:0] p, input logic [AW-1:0] dst,
                         input int len, input bit auto_go, input logic [AW-1:0] nxt);
    logic [DW-1:0] lw;
    lw = 32'h0055_0000 | DW'(len);
    mem[p] = DW'(dst); mem[p+1] = lw; mem[p+2] = DW'(auto_go); mem[p+3] = DW'(nxt);
    for (int k = 0; k < len; k++) exp_q.push_back({dst + AW'(k), mem[SRC + AW'(k)]});
    exp_q.push_back({p + AW'(1), lw | 32'h8000_0000});
  endtask

  task automatic wait_irq(input bit xfer, input string rq);
    int n = 0;
    while (((xfer ? irq_xfer : irq_buf) !== 1'b1) && n < 3000) begin @(negedge clk); n++; end
    if (n >= 3000) chk({rq, " interrupt never raised"}, 0, 1);
  endtask

  initial begin
    #(200000 * 10);
    fails++; tests++;
    $display("FAIL watchdog expired (all requirements)");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [DW-1:0] v;
    int busy;
    for (int i = 0; i < 256; i++) mem[i] = '0;
    for (int k = 0; k < 8; k++) mem[SRC + AW'(k)] = 32'hA000_0000 + DW'(k * 7 + 1);
    rst_n = 1'b0; reg_wr = 1'b0; reg_rd = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // reset state
    chk("R10 no request after reset", DW'(mem_req), 0);
    chk("R2 irq outputs after reset", DW'({irq_xfer, irq_buf}), 0);
    rd(2'd0, v); chk("R1 enable after reset", v, 0);
    rd(2'd3, v); chk("R2 status after reset", v, 0);

    // chain of three: lengths 3, 0 and 2, all automatic
    put_lli(8'h40, 8'h80, 3, 1'b1, 8'h48);
    put_lli(8'h48, 8'h90, 0, 1'b1, 8'h50);   // R11 zero length
    put_lli(8'h50, 8'hA0, 2, 1'b1, 8'h00);
    wr(2'd1, DW'(SRC));
    wr(2'd2, 32'h40);
    busy = 0;
    for (int c = 0; c < 20; c++) begin @(negedge clk); if (mem_req) busy++; end
    chk("R8 silent before enable", DW'(busy), 0);
    wr(2'd0, 32'h1);
    rd(2'd0, v); chk("R1 enable while running", v, 1);
    wait_irq(1'b1, "R7");
    chk("R4/R5/R11 all expected writes seen", DW'(exp_q.size()), 0);
    chk("R3/R4 first dst word", mem[8'h80], mem[SRC]);
    chk("R4 source replayed for last buffer", mem[8'hA1], mem[SRC + 1]);
    chk("R11 zero length left dst untouched", mem[8'h90], 0);
    rd(2'd3, v); chk("R6/R7 status after three buffers", v, 3);
    rd(2'd3, v); chk("R2 status cleared by read", v, 0);
    chk("R2 irq outputs follow cleared status", DW'({irq_xfer, irq_buf}), 0);
    rd(2'd0, v); chk("R1/R7 channel free after chain", v, 0);

    // single buffer: no buffer-complete
    put_lli(8'h70, 8'hD0, 4, 1'b0, 8'h00);
    wr(2'd2, 32'h70);
    wr(2'd0, 32'h1);
    wait_irq(1'b1, "R7");
    chk("R5 single buffer writes seen", DW'(exp_q.size()), 0);
    rd(2'd3, v); chk("R6 last buffer sets no buffer status", v, 2);

    // non-automatic first buffer pauses
    put_lli(8'h60, 8'hB0, 2, 1'b0, 8'h68);
    put_lli(8'h68, 8'hC0, 1, 1'b1, 8'h00);
    wr(2'd2, 32'h60);
    wr(2'd0, 32'h1);
    wait_irq(1'b0, "R6");
    busy = 0;
    for (int c = 0; c < 30; c++) begin @(negedge clk); if (mem_req) busy++; end
    chk("R9 paused without automatic bit", DW'(busy), 0);
    chk("R9 no completion while paused", DW'(irq_xfer), 0);
    rd(2'd0, v); chk("R1 enable held while paused", v, 1);
    wr(2'd0, 32'h2);
    wait_irq(1'b1, "R9");
    chk("R9 resumed chain writes seen", DW'(exp_q.size()), 0);
    chk("R4 resumed buffer data", mem[8'hC0], mem[SRC]);
    rd(2'd3, v); chk("R2/R6 status after paused chain", v, 3);
    rd(2'd0, v); chk("R7 enable cleared", v, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule